// File: doc/BRIEF.md
# Sleep Wake-up Sequencer

This block decides how a small processor core comes back from its low-power sleep state. Each instruction cycle is made of a fixed number of clock phases, four by default. The block keeps its own phase count. It samples the core's sleep request only in the last phase of an instruction cycle, and it samples the interrupt flag only in that phase as well. When it sees the interrupt flag while the core is asleep, it looks at the clock-mode code. For a crystal-type oscillator mode it first runs a start-up timer of a fixed number of oscillator clocks. For any other mode it lets execution resume at the next boundary.

On resumption the core first executes the instruction that was already fetched before sleep. What follows depends on the global interrupt enable, which is captured when the wake-up is sampled. If the enable was set, the block marks one dummy instruction cycle and tells the core to load the interrupt vector as its next PC. If the enable was clear, the core simply carries on in line. A reset at any moment, including in the middle of the start-up count, returns the block to the running state.

Top module: `wake_sequencer`

## Requirements
- R1: While reset is low and at the first sample after reset, run_o=1, pc_sel_o=0 and dummy_o=0, and the phase count starts at 0. Boundary edges are therefore every PHASES-th rising clock edge after release.
- R2: sleep_i is acted on only at a boundary edge, which is the last phase of an instruction cycle. If sleep_i is high there while running, run_o is 0 right after that edge. A sleep_i pulse in any other phase leaves run_o at 1.
- R3: While asleep, int_flag_i is sampled only at boundary edges. A pulse of the flag in any other phase leaves run_o at 0.
- R4: For clock-mode codes 0, 1 and 2 (crystal group), a wake sampled at boundary edge E keeps run_o at 0 through edge E+OST_CYCLES-1. run_o becomes 1 right after edge E+OST_CYCLES.
- R5: For clock-mode codes 3 to 7, run_o becomes 1 right after the boundary edge at which the wake is sampled.
- R6: Reset during the start-up count returns the block at once to run_o=1 with dummy_o=0. No resume or dummy cycle follows once reset is released.
- R7: If gie_i=1 at the wake sample, the first instruction cycle after resumption has dummy_o=0 and pc_sel_o=0. The next cycle has dummy_o=1 and pc_sel_o=1 (load vector). After that the block returns to normal running with both outputs at 0.
- R8: If gie_i=0 at the wake sample, no dummy cycle occurs and pc_sel_o stays 0 throughout.
- R9: gie_i and clk_mode_i are captured at the wake sample. Changes to them afterwards alter neither the delay nor the dummy cycle.
- R10: While asleep or during the start-up count, run_o=0 and dummy_o=0.
- R11: sleep_i is ignored during the resume and dummy cycles.
- R12: If sleep_i and int_flag_i are both high at the same boundary edge while running, the core sleeps, and it wakes at the next boundary edge if the flag is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one phase per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Core requests sleep (sampled at last phase) |
| int_flag_i | input | 1 | Pending interrupt flag |
| gie_i | input | 1 | Global interrupt enable |
| clk_mode_i | input | 3 | Oscillator mode code; 0..2 need start-up delay |
| run_o | output | 1 | 1: core executes; 0: core stalled |
| pc_sel_o | output | 1 | 0: next PC is PC+1; 1: next PC is the interrupt vector |
| dummy_o | output | 1 | Marks the dummy instruction cycle |

## Verification
The sleep request and the interrupt flag can both be high at the same boundary edge. The bench provokes this by raising both before one boundary edge while the core runs. It expects run_o to be low for exactly one instruction cycle and high again after the next boundary. A second collision puts a sleep request on the boundary that ends the resume cycle of a vectored wake. Here the dummy cycle must still appear and running must continue.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_OST    = 3'd2,
    ST_RESUME = 3'd3,
    ST_DUMMY  = 3'd4
  } wake_state_e;

  localparam int unsigned MODE_W = 3;

  localparam logic PC_SEL_INC = 1'b0;
  localparam logic PC_SEL_VEC = 1'b1;

  // codes 0..2 are crystal-type oscillators that need a start-up count
  localparam logic [MODE_W-1:0] MODE_XTAL_MAX = 3'd2;

  function automatic logic mode_needs_ost(logic [MODE_W-1:0] mode);
    return (mode <= MODE_XTAL_MAX);
  endfunction

endpackage

// File: rtl/wake_phase_gen.sv
module wake_phase_gen #(
  parameter int unsigned PHASES = 4,
  localparam int unsigned PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (ph_q == PH_W'(PHASES - 1))   ph_q <= '0;
    else                                  ph_q <= ph_q + 1'b1;
  end

  assign phase_o = ph_q;
  assign last_o  = (ph_q == PH_W'(PHASES - 1));

  a_r1_phase_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (phase_o == '0));

  a_r1_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(phase_o) < PHASES));

endmodule

// File: rtl/wake_ost_timer.sv
module wake_ost_timer #(
  parameter int unsigned OST_CYCLES = 1024,
  localparam int unsigned CNT_W     = $clog2(OST_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic en_i,
  output logic done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(OST_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= '0;
    else if (en_i && !at_end) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = at_end;

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(cnt_q) <= OST_CYCLES - 1));

  a_r4_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0));

endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
  import wake_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic              sleep_i,
  input  logic              int_flag_i,
  input  logic              gie_i,
  input  logic [MODE_W-1:0] clk_mode_i,
  input  logic              ost_done_i,
  output logic              ost_start_o,
  output logic              ost_en_o,
  output logic              run_o,
  output logic              pc_sel_o,
  output logic              dummy_o
);

  wake_state_e state_q, state_d;
  logic        gie_q, gie_d;
  logic        wake_hit;

  assign wake_hit = (state_q == ST_SLEEP) && last_i && int_flag_i;

  always_comb begin
    state_d = state_q;
    gie_d   = gie_q;
    unique case (state_q)
      ST_RUN:    if (last_i && sleep_i) state_d = ST_SLEEP;
      ST_SLEEP:  if (wake_hit) begin
                   gie_d   = gie_i;
                   state_d = mode_needs_ost(clk_mode_i) ? ST_OST : ST_RESUME;
                 end
      ST_OST:    if (last_i && ost_done_i) state_d = ST_RESUME;
      ST_RESUME: if (last_i) state_d = gie_q ? ST_DUMMY : ST_RUN;
      ST_DUMMY:  if (last_i) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      gie_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      gie_q   <= gie_d;
    end
  end

  assign ost_start_o = wake_hit && mode_needs_ost(clk_mode_i);
  assign ost_en_o    = (state_q == ST_OST);
  assign run_o       = (state_q == ST_RUN) || (state_q == ST_RESUME) || (state_q == ST_DUMMY);
  assign dummy_o     = (state_q == ST_DUMMY);
  assign pc_sel_o    = (state_q == ST_DUMMY) ? PC_SEL_VEC : PC_SEL_INC;

  a_r2_sleep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RUN) && last_i && sleep_i) |=> !run_o);

  a_r3_resume_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(last_i));

  a_r4_ost_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_OST) && !ost_done_i) |=> !run_o);

  a_r7_dummy_after_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dummy_o) |-> $past(run_o && !dummy_o));

  a_r8_dummy_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dummy_o) |-> gie_q);

  a_r10_quiet_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> !dummy_o && (pc_sel_o == PC_SEL_INC));

  a_r11_no_sleep_in_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RESUME) && last_i && sleep_i) |=> run_o);

endmodule

// File: rtl/wake_sequencer.sv
module wake_sequencer
  import wake_seq_pkg::*;
#(
  parameter int unsigned PHASES     = 4,
  parameter int unsigned OST_CYCLES = 1024,
  localparam int unsigned PH_W      = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       int_flag_i,
  input  logic       gie_i,
  input  logic [2:0] clk_mode_i,
  output logic       run_o,
  output logic       pc_sel_o,
  output logic       dummy_o
);

  logic [PH_W-1:0] phase;
  logic            last;
  logic            ost_start, ost_en, ost_done;

  wake_phase_gen #(.PHASES(PHASES)) i_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .last_o  (last)
  );

  wake_ost_timer #(.OST_CYCLES(OST_CYCLES)) i_ost (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ost_start),
    .en_i    (ost_en),
    .done_o  (ost_done)
  );

  wake_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .last_i      (last),
    .sleep_i     (sleep_i),
    .int_flag_i  (int_flag_i),
    .gie_i       (gie_i),
    .clk_mode_i  (clk_mode_i),
    .ost_done_i  (ost_done),
    .ost_start_o (ost_start),
    .ost_en_o    (ost_en),
    .run_o       (run_o),
    .pc_sel_o    (pc_sel_o),
    .dummy_o     (dummy_o)
  );

  // a dummy cycle is always a whole instruction cycle wide
  a_r7_dummy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dummy_o) && (PHASES > 1)) |-> (phase == '0));

  a_r6_reset_run: assert property (@(posedge clk_i)
    !rst_ni |-> run_o && !dummy_o);

endmodule

// File: tb/test_wake_sequencer.sv
module test_wake_sequencer;

  localparam int unsigned N = 1024;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sleep_i = 1'b0;
  logic       int_flag_i = 1'b0;
  logic       gie_i = 1'b0;
  logic [2:0] clk_mode_i = 3'd3;
  logic       run_o, pc_sel_o, dummy_o;

  int checks = 0;
  int failures = 0;
  int edges = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  wake_sequencer #(.PHASES(4), .OST_CYCLES(N)) i_wake_sequencer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_i    (sleep_i),
    .int_flag_i (int_flag_i),
    .gie_i      (gie_i),
    .clk_mode_i (clk_mode_i),
    .run_o      (run_o),
    .pc_sel_o   (pc_sel_o),
    .dummy_o    (dummy_o)
  );

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) edges <= 0;
    else         edges <= edges + 1;

  typedef struct {
    int    at;
    logic  run;
    logic  sel;
    logic  dmy;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_item;

  task automatic compare(string tag, logic r, logic s, logic d, logic er, logic es, logic ed);
    checks++;
    if ({r, s, d} !== {er, es, ed}) begin
      failures++;
      $display("FAIL %s: run/sel/dummy=%b%b%b expected %b%b%b", tag, r, s, d, er, es, ed);
    end
  endtask

  task automatic push(int at, logic r, logic s, logic d, string tag);
    exp_t it;
    it.at = at; it.run = r; it.sel = s; it.dmy = d; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic push_span(int from, int to, logic r, logic s, logic d, string tag);
    for (int i = from; i <= to; i++) push(i, r, s, d, tag);
  endtask

  // monitor: compares design outputs against queued expectations
  always @(negedge clk_i) begin
    while (sb_q.size() > 0 && sb_q[0].at <= edges) begin
      mon_item = sb_q.pop_front();
      if (mon_item.at < edges) begin
        checks++;
        failures++;
        $display("FAIL %s: sample at edge %0d missed (now %0d)", mon_item.tag, mon_item.at, edges);
      end else begin
        compare(mon_item.tag, run_o, pc_sel_o, dummy_o, mon_item.run, mon_item.sel, mon_item.dmy);
      end
    end
  end

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // returns at the negedge just before boundary edge b
  task automatic to_boundary(output int b);
    do @(negedge clk_i); while ((edges % 4) != 3);
    b = edges + 1;
  endtask

  task automatic go_sleep();
    int b;
    drain();
    to_boundary(b);
    sleep_i = 1'b1;
    push(b, 1'b0, 1'b0, 1'b0, "R2");
    @(negedge clk_i);
    sleep_i = 1'b0;
    drain();
  endtask

  initial begin
    int b, e;
    push_span(0, 3, 1'b1, 1'b0, 1'b0, "R1");
    #23;
    @(posedge clk_i);
    #3 rst_ni = 1'b1;
    drain();

    // R2: sleep pulse off the boundary is ignored
    do @(negedge clk_i); while ((edges % 4) != 0);
    sleep_i = 1'b1;
    e = edges;
    @(negedge clk_i);
    sleep_i = 1'b0;
    push_span(e + 2, e + 5, 1'b1, 1'b0, 1'b0, "R2");
    drain();

    // R2/R10: sleep on boundary
    to_boundary(b);
    sleep_i = 1'b1;
    push(b, 1'b0, 1'b0, 1'b0, "R2");
    push_span(b + 1, b + 3, 1'b0, 1'b0, 1'b0, "R10");
    @(negedge clk_i);
    sleep_i = 1'b0;
    drain();

    // R3: flag pulse off the boundary does not wake
    do @(negedge clk_i); while ((edges % 4) != 1);
    int_flag_i = 1'b1;
    e = edges;
    @(negedge clk_i);
    int_flag_i = 1'b0;
    push_span(e + 2, e + 7, 1'b0, 1'b0, 1'b0, "R3");
    drain();

    // R5/R8: non-crystal mode, interrupts disabled
    to_boundary(b);
    int_flag_i = 1'b1; clk_mode_i = 3'd3; gie_i = 1'b0;
    push_span(b, b + 3, 1'b1, 1'b0, 1'b0, "R5");
    push_span(b + 4, b + 8, 1'b1, 1'b0, 1'b0, "R8");
    @(negedge clk_i);
    int_flag_i = 1'b0;
    drain();

    // R4/R7/R9/R11: crystal mode, interrupts enabled, inputs changed later
    go_sleep();
    to_boundary(b);
    int_flag_i = 1'b1; clk_mode_i = 3'd1; gie_i = 1'b1;
    push(b, 1'b0, 1'b0, 1'b0, "R10");
    push(b + N / 2, 1'b0, 1'b0, 1'b0, "R9");
    push(b + N - 1, 1'b0, 1'b0, 1'b0, "R4");
    push(b + N, 1'b1, 1'b0, 1'b0, "R4");
    push(b + N + 3, 1'b1, 1'b0, 1'b0, "R7");
    push_span(b + N + 4, b + N + 7, 1'b1, 1'b1, 1'b1, "R9");
    push(b + N + 8, 1'b1, 1'b0, 1'b0, "R11");
    push(b + N + 12, 1'b1, 1'b0, 1'b0, "R11");
    @(negedge clk_i);
    int_flag_i = 1'b0; gie_i = 1'b0; clk_mode_i = 3'd3;
    while (edges != b + N + 3) @(negedge clk_i);
    sleep_i = 1'b1;
    @(negedge clk_i);
    sleep_i = 1'b0;
    drain();

    // R5/R7: out-of-group mode code, interrupts enabled
    go_sleep();
    to_boundary(b);
    int_flag_i = 1'b1; clk_mode_i = 3'd7; gie_i = 1'b1;
    push_span(b, b + 3, 1'b1, 1'b0, 1'b0, "R5");
    push_span(b + 4, b + 7, 1'b1, 1'b1, 1'b1, "R7");
    push(b + 8, 1'b1, 1'b0, 1'b0, "R7");
    @(negedge clk_i);
    int_flag_i = 1'b0; gie_i = 1'b0;
    drain();

    // R12: sleep and flag on the same boundary
    to_boundary(b);
    sleep_i = 1'b1; int_flag_i = 1'b1; clk_mode_i = 3'd4;
    push_span(b, b + 3, 1'b0, 1'b0, 1'b0, "R12");
    push_span(b + 4, b + 8, 1'b1, 1'b0, 1'b0, "R12");
    @(negedge clk_i);
    sleep_i = 1'b0;
    while (edges != b + 5) @(negedge clk_i);
    int_flag_i = 1'b0;
    drain();

    // R6: reset in the middle of the start-up count
    go_sleep();
    to_boundary(b);
    int_flag_i = 1'b1; clk_mode_i = 3'd2; gie_i = 1'b1;
    @(negedge clk_i);
    int_flag_i = 1'b0;
    repeat (100) @(negedge clk_i);
    compare("R6", run_o, pc_sel_o, dummy_o, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b0;
    #1;
    compare("R6", run_o, pc_sel_o, dummy_o, 1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk_i);
    push(0, 1'b1, 1'b0, 1'b0, "R6");
    push(N, 1'b1, 1'b0, 1'b0, "R6");
    push_span(N + 1, N + 8, 1'b1, 1'b0, 1'b0, "R6");
    @(posedge clk_i);
    #3 rst_ni = 1'b1;
    drain();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule